// File: doc/BRIEF.md
# Serial Decimal-to-Binary Converter

This block turns an unsigned packed-BCD number of up to ten digits into a 32-bit binary value. It does not accumulate by tens. It divides the whole decimal field by sixteen again and again. Each division leaves a remainder from 0 to 15, and that remainder is the next hexadecimal digit of the result, starting with the least significant. The quotient replaces the decimal field, so the field loses significant digits as the work goes on. The run stops when the field reaches zero.

Each division walks the field digit by digit, one digit per clock, starting at the most significant nonzero digit. It carries a running remainder and forms remainder*10+digit at every step. Digits above the highest nonzero one are skipped. Because of this, the conversion time depends on how many significant digits the value has. A caller waits for `ready`, pulses `start` with the BCD word, and then waits for the one-cycle `done` pulse. The result and its flags stay valid until the next accepted start.

Top module: `bcd_to_bin_serial`

## Requirements
- R1: After reset, ready is 1, and done, overflow, invalid and bin_out are all 0.
- R2: A start seen while ready is 1 is accepted. Ready is 0 from the next cycle until done has been high.
- R3: For a valid input, bin_out equals the decimal value modulo 2^32. The first remainder fills bits 3:0, the second fills bits 7:4, and so on.
- R4: Overflow is 1 exactly when the decimal value is 4294967296 or more. In that case bin_out holds the low 32 bits of the value.
- R5: If any input nibble is greater than 9, invalid is 1, bin_out is 0, overflow is 0, and done is high in the first cycle after the accepting edge.
- R6: For a valid input, let L_k be the count of significant decimal digits at the start of pass k. Done is high in cycle 2 + Σ(1+L_k) after the accepting edge, counting the cycle right after that edge as cycle 1. A zero input gives done in cycle 2.
- R7: Done is high for exactly one cycle and is followed by ready. bin_out, overflow and invalid stay unchanged until the next accepted start.
- R8: A start raised while ready is 0 is ignored. It neither changes the result nor the timing of the conversion in progress.
- R9: Digit i of the input sits at bits 4i+3:4i, and digit 0 is the least significant.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Request to convert bcd_in, taken when ready is 1 |
| bcd_in | input | 40 | Packed BCD operand, ten digits |
| ready | output | 1 | Idle and able to accept start |
| done | output | 1 | One-cycle pulse when the result is final |
| bin_out | output | 32 | Binary result |
| overflow | output | 1 | Value did not fit in 32 bits |
| invalid | output | 1 | A nibble above 9 was presented |

## Verification
Zero and single-digit inputs check the shortest pass count and the final test for an empty field. The values 4294967295 and 4294967296 sit on either side of the overflow boundary, and 9999999999 gives the longest run. Random ten-digit values, and random values with leading zeros, show whether the digit-count-dependent latency and the digit ordering are right. Inputs with a nibble above 9, either low in the word or at the top, must be rejected after one cycle. A start pulse raised during a busy conversion must leave both the result and the done cycle unchanged.

// File: rtl/bcd2b_pkg.sv
package bcd2b_pkg;
   typedef enum logic [1:0] {
      ST_IDLE = 2'd0,
      ST_PASS = 2'd1,
      ST_STEP = 2'd2,
      ST_FIN  = 2'd3
   } conv_state_t;

   function automatic int max_int(input int a, input int b);
      return (a > b) ? a : b;
   endfunction
endpackage

// File: rtl/bcd_nibble_check.sv
module bcd_nibble_check #(
   parameter int DIGITS = 10
) (
   input  logic [4*DIGITS-1:0] field,
   output logic                any_bad
);
   logic [DIGITS-1:0] bad;

   for (genvar g = 0; g < DIGITS; g++) begin : g_nib
      assign bad[g] = (field[4*g +: 4] > 4'd9);
   end

   assign any_bad = |bad;
endmodule

// File: rtl/bcd_msd_find.sv
module bcd_msd_find #(
   parameter int DIGITS = 10,
   parameter bit SHRINK = 1'b1,
   parameter int IDX_W  = $clog2(DIGITS)
) (
   input  logic [4*DIGITS-1:0] field,
   output logic [IDX_W-1:0]    msd_idx,
   output logic                nonzero
);
   assign nonzero = |field;

   if (SHRINK) begin : g_shrink
      always_comb begin
         msd_idx = '0;
         for (int i = 0; i < DIGITS; i++) begin
            if (field[4*i +: 4] != 4'd0) msd_idx = IDX_W'(i);
         end
      end
   end else begin : g_full
      assign msd_idx = IDX_W'(DIGITS - 1);
   end
endmodule

// File: rtl/bcd_div16_step.sv
module bcd_div16_step (
   input  logic [3:0] rem_in,
   input  logic [3:0] digit,
   output logic [3:0] quot,
   output logic [3:0] rem_out
);
   logic [7:0] partial;

   assign partial = ({4'd0, rem_in} << 3) + ({4'd0, rem_in} << 1) + {4'd0, digit};
   assign quot    = partial[7:4];
   assign rem_out = partial[3:0];
endmodule

// File: rtl/bcd_to_bin_serial.sv
module bcd_to_bin_serial
   import bcd2b_pkg::*;
#(
   parameter int DIGITS = 10,
   parameter int OUT_W  = 32,
   parameter bit SHRINK = 1'b1
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                start,
   input  logic [4*DIGITS-1:0] bcd_in,
   output logic                ready,
   output logic                done,
   output logic [OUT_W-1:0]    bin_out,
   output logic                overflow,
   output logic                invalid
);
   localparam int NHEX  = OUT_W / 4;
   localparam int IDX_W = $clog2(DIGITS);
   localparam int MAXP  = max_int(DIGITS, NHEX) + 1;
   localparam int HEX_W = $clog2(MAXP + 1);

   if (DIGITS < 2) begin : g_chk_digits
      $error("DIGITS must be at least 2");
   end
   if ((OUT_W % 4) != 0 || OUT_W < 4) begin : g_chk_width
      $error("OUT_W must be a positive multiple of 4");
   end

   conv_state_t          state_q;
   logic [4*DIGITS-1:0]  field_q;
   logic [3:0]           rem_q;
   logic [IDX_W-1:0]     pos_q;
   logic [HEX_W-1:0]     hex_q;
   logic [OUT_W-1:0]     result_q;
   logic                 ovf_q;
   logic                 inv_q;

   logic                 in_bad;
   logic [IDX_W-1:0]     msd_idx;
   logic                 field_nz;
   logic [3:0]           cur_digit;
   logic [3:0]           quot;
   logic [3:0]           rem_nx;

   bcd_nibble_check #(.DIGITS(DIGITS)) u_check (
      .field   (bcd_in),
      .any_bad (in_bad)
   );

   bcd_msd_find #(.DIGITS(DIGITS), .SHRINK(SHRINK), .IDX_W(IDX_W)) u_msd (
      .field   (field_q),
      .msd_idx (msd_idx),
      .nonzero (field_nz)
   );

   assign cur_digit = field_q[4*pos_q +: 4];

   bcd_div16_step u_step (
      .rem_in  (rem_q),
      .digit   (cur_digit),
      .quot    (quot),
      .rem_out (rem_nx)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q  <= ST_IDLE;
         field_q  <= '0;
         rem_q    <= '0;
         pos_q    <= '0;
         hex_q    <= '0;
         result_q <= '0;
         ovf_q    <= 1'b0;
         inv_q    <= 1'b0;
      end else begin
         unique case (state_q)
            ST_IDLE: begin
               if (start) begin
                  field_q  <= bcd_in;
                  result_q <= '0;
                  ovf_q    <= 1'b0;
                  inv_q    <= in_bad;
                  hex_q    <= '0;
                  state_q  <= in_bad ? ST_FIN : ST_PASS;
               end
            end
            ST_PASS: begin
               if (!field_nz) begin
                  state_q <= ST_FIN;
               end else begin
                  pos_q   <= msd_idx;
                  rem_q   <= '0;
                  state_q <= ST_STEP;
               end
            end
            ST_STEP: begin
               field_q[4*pos_q +: 4] <= quot;
               rem_q                 <= rem_nx;
               if (pos_q == '0) begin
                  for (int h = 0; h < NHEX; h++) begin
                     if (hex_q == HEX_W'(h)) result_q[4*h +: 4] <= rem_nx;
                  end
                  if (hex_q >= HEX_W'(NHEX) && rem_nx != 4'd0) ovf_q <= 1'b1;
                  if (hex_q != {HEX_W{1'b1}}) hex_q <= hex_q + 1'b1;
                  state_q <= ST_PASS;
               end else begin
                  pos_q <= pos_q - 1'b1;
               end
            end
            ST_FIN: state_q <= ST_IDLE;
            default: state_q <= ST_IDLE;
         endcase
      end
   end

   assign ready    = (state_q == ST_IDLE);
   assign done     = (state_q == ST_FIN);
   assign bin_out  = result_q;
   assign overflow = ovf_q;
   assign invalid  = inv_q;

   assert_accept_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (start && ready) |=> !ready);

   assert_done_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> (!done && ready));

   assert_hold_result_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (ready && !start) |=> ($stable(bin_out) && $stable(overflow) && $stable(invalid)));

   assert_reject_clean_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (done && invalid) |-> (bin_out == '0 && !overflow));

   assert_digit_range_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == ST_STEP) |-> (cur_digit <= 4'd9 && quot <= 4'd9));

   assert_busy_ignores_start_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (start && !ready && !done) |=> !ready);
endmodule

// File: tb/test_bcd_to_bin_serial.sv
module test_bcd_to_bin_serial;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        start = 1'b0;
   logic [39:0] bcd_in = '0;
   logic        ready, done, overflow, invalid;
   logic [31:0] bin_out;

   int checks = 0;
   int fails  = 0;

   always #5 clk = ~clk;

   bcd_to_bin_serial i_bcd_to_bin_serial (
      .clk(clk), .rst_n(rst_n), .start(start), .bcd_in(bcd_in),
      .ready(ready), .done(done), .bin_out(bin_out),
      .overflow(overflow), .invalid(invalid)
   );

   task automatic chk(input bit ok, input string req, input longint act, input longint exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   function automatic int dec_len(input longint v);
      int n = 0;
      while (v > 0) begin n++; v = v / 10; end
      return n;
   endfunction

   function automatic logic [39:0] to_bcd(input longint v);
      logic [39:0] b = '0;
      for (int i = 0; i < 10; i++) begin
         b[4*i +: 4] = 4'(v % 10);
         v = v / 10;
      end
      return b;
   endfunction

   // one conversion, compared against a behavioural model on every cycle
   task automatic run(input logic [39:0] word, input bit poke_busy);
      bit     valid = 1'b1;
      longint val = 0;
      longint t;
      int     busy;
      int     k;
      bit     seen;
      for (int i = 9; i >= 0; i--) begin
         if (word[4*i +: 4] > 4'd9) valid = 1'b0;
         val = val * 10 + longint'(word[4*i +: 4]);
      end
      if (valid) begin
         busy = 1;
         t = val;
         while (t > 0) begin busy += 1 + dec_len(t); t = t / 16; end
      end else begin
         busy = 0;
      end
      @(negedge clk);
      chk(ready == 1'b1, "R2 ready before start", ready, 1);
      start = 1'b1; bcd_in = word;
      @(negedge clk);
      start = 1'b0;
      k = 1; seen = 1'b0;
      while (!seen && k < 2000) begin
         if (poke_busy && k == 2) begin start = 1'b1; bcd_in = 40'h1234567890; end
         else if (poke_busy && k == 3) start = 1'b0;
         if (done) begin
            seen = 1'b1;
            chk(k == busy + 1, valid ? "R6 done cycle" : "R5 reject cycle", k, busy + 1);
            if (!poke_busy) chk(ready == 1'b0, "R2 ready low at done", ready, 0);
         end else begin
            if (k <= busy) chk(ready == 1'b0, "R2 ready low while busy", ready, 0);
            @(negedge clk);
            k++;
         end
      end
      if (!seen) chk(1'b0, "R6 no done", k, busy + 1);
      start = 1'b0;
      if (valid) begin
         chk(invalid == 1'b0, "R5 invalid clear", invalid, 0);
         chk(bin_out == val[31:0], poke_busy ? "R8 result" : "R3 result", bin_out, val[31:0]);
         chk(overflow == (val > 64'hFFFF_FFFF), "R4 overflow", overflow, val > 64'hFFFF_FFFF);
      end else begin
         chk(invalid == 1'b1, "R5 invalid set", invalid, 1);
         chk(bin_out == 0 && overflow == 1'b0, "R5 cleared outputs", bin_out, 0);
      end
      @(negedge clk);
      chk(done == 1'b0 && ready == 1'b1, "R7 single done pulse", done, 0);
      chk(bin_out == (valid ? val[31:0] : 32'd0), "R7 result held", bin_out, valid ? val[31:0] : 0);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      fails++; checks++;
      $display("FAIL watchdog expired actual=timeout expected=finish");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      chk(ready == 1'b1 && done == 1'b0, "R1 reset handshake", {ready, done}, 2);
      chk(bin_out == 0 && !overflow && !invalid, "R1 reset outputs", bin_out, 0);
      rst_n = 1'b1;
      @(negedge clk);
      chk(ready == 1'b1, "R1 ready after reset", ready, 1);
      run(40'h0000000000, 1'b0);               // R6 zero input
      run(40'h0000000005, 1'b0);               // R3 one digit
      run(40'h0000000016, 1'b0);               // R3 two hex digits
      run(40'h1000000000, 1'b0);               // R9 top digit position
      run(40'h4294967295, 1'b0);               // R4 largest fitting value
      run(40'h4294967296, 1'b0);               // R4 first overflow value
      run(40'h9999999999, 1'b0);               // R4 longest run
      run(40'h00000000A0, 1'b0);               // R5 bad low nibble
      run(40'hF000000000, 1'b0);               // R5 bad top nibble
      run(40'h0000987654, 1'b1);               // R8 start while busy
      for (int n = 0; n < 150; n++) begin
         longint v = 0;
         int     len = 1 + int'($urandom % 10);
         for (int d = 0; d < len; d++) v = v * 10 + longint'($urandom % 10);
         run(to_bcd(v), 1'b0);                 // R3 R6 random values
      end
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end
endmodule